// File: doc/BRIEF.md
# Two-lane conditional mirror swapper

This block performs one crush pass over an N-entry byte state array that lives outside the block. The array is split into mirrored pairs: entry v and entry N-1-v, for every v below N/2. For each pair the block compares the two stored bytes as unsigned numbers. If the lower-index entry holds the larger value, the two entries are exchanged. Otherwise the pair is left alone. When the pass ends, every mirrored pair is in ascending order.

No pair shares a location with any other pair, so the pairs can be handled in any order. The block runs LANES compare-and-swap lanes side by side, two by default. Each lane uses one read port and one write port for each end of its pair, so the default build stays within four reads and four writes per cycle. In a busy cycle, lane l handles v = s*LANES + l, where s is the step number. A whole pass therefore takes a fixed N/(2*LANES) cycles, which is N/4 with the default lanes.

The array is read combinationally: read data is valid in the same cycle as the read address. Writes are committed by the array at the clock edge that ends the busy cycle. A one-cycle start pulse launches a pass. A one-cycle done pulse marks the point where all writes have landed. The surrounding shuffle sequencer invokes the block twice per shuffle, once after each of the first two whip phases.

Top module: `mirror_crush`

## Requirements
- R1: After a pass, S[v] <= S[N-1-v] as unsigned bytes for every v in 0..N/2-1.
- R2: A pair with S[v] > S[N-1-v] is exchanged. A pair with S[v] <= S[N-1-v], equal values included, gets no write at all: both write enables of its lane stay 0 that cycle.
- R3: The comparison is unsigned. A lower entry of 8'h80 against an upper entry of 8'h7F is exchanged.
- R4: If start is sampled while idle, done is high for exactly one cycle, starting on the N/(2*LANES)-th rising edge after the edge that sampled start.
- R5: Read ports are numbered from 0, and each group of AW bits in the address buses, least significant first, is one port. In busy step s, lane l drives read port 2l with v = s*LANES + l and read port 2l+1 with N-1-v. A swapping lane writes the old upper value to v through write port 2l and the old lower value to N-1-v through write port 2l+1. rdValid is high exactly in the busy cycles.
- R6: A start that arrives while a pass is in progress is ignored. The pass keeps its length and no second pass follows.
- R7: A pass never changes the multiset of values held in the array.
- R8: During reset and while idle, done, rdValid and every write enable are 0.
- R9: A start that arrives in the same cycle as done is accepted and begins a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a pass when the block is idle |
| done | output | 1 | One-cycle pulse once the last writes have landed |
| rdValid | output | 1 | High in the cycles where the read addresses are in use |
| rdAddr | output | 2*LANES*AW | Read addresses, one AW-bit group per port |
| rdData | input | 2*LANES*W | Combinational read data, one W-bit group per port |
| wrEn | output | 2*LANES | Write enable for each write port |
| wrAddr | output | 2*LANES*AW | Write addresses, one AW-bit group per port |
| wrData | output | 2*LANES*W | Write data, one W-bit group per port |

## Verification
The bench builds the block with N=16, LANES=2 and W=8, so a pass is four busy cycles long. At that size a random permutation mixes ordered pairs and reversed pairs in almost every pass, so each lane sees both swap and no-swap cycles. The small array also makes it cheap to check the whole array after every pass, to check the multiset, and to predict the read addresses of every step. With the byte width at its default of 8, a crafted array can place 8'h80 against 8'h7F and so exercise the unsigned comparison.

// File: rtl/crush_pkg.sv
package crush_pkg;

  typedef enum logic {
    CR_IDLE = 1'b0,
    CR_BUSY = 1'b1
  } crushState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearIdx;  // load the pair index with zero
    logic advance;   // step the pair index by LANES
    logic writeOk;   // lanes may issue writes this cycle
  } crushStrobes_t;

endpackage

// File: rtl/crush_ctrl.sv
module crush_ctrl
  import crush_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          atLast,
  output crushStrobes_t strobes,
  output logic          busy,
  output logic          done
);

  crushState_e state;

  always_comb begin
    strobes.clearIdx = (state == CR_IDLE) && start;
    strobes.advance  = (state == CR_BUSY);
    strobes.writeOk  = (state == CR_BUSY);
  end

  assign busy = (state == CR_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CR_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == CR_BUSY) && atLast;
      case (state)
        CR_IDLE: if (start) state <= CR_BUSY;
        CR_BUSY: if (atLast) state <= CR_IDLE;
        default: state <= CR_IDLE;
      endcase
    end
  end

  // R4: done lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: done only follows a busy cycle
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(state == CR_BUSY));

  // R6: start cannot cut a pass short or restart it
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == CR_BUSY && !atLast) |=> (state == CR_BUSY && !done));

endmodule

// File: rtl/crush_lane.sv
module crush_lane #(
  parameter int N       = 256,
  parameter int W       = 8,
  parameter int AW      = 8,
  parameter int LANE_ID = 0
) (
  input  logic [AW-1:0] baseIdx,
  input  logic          writeOk,
  output logic [AW-1:0] loAddr,
  output logic [AW-1:0] hiAddr,
  input  logic [W-1:0]  loData,
  input  logic [W-1:0]  hiData,
  output logic          swapEn,
  output logic [W-1:0]  loWrData,
  output logic [W-1:0]  hiWrData
);

  localparam logic [AW-1:0] TOP_IDX = AW'(N - 1);
  localparam logic [AW-1:0] OFFSET  = AW'(LANE_ID);

  always_comb begin
    loAddr   = baseIdx + OFFSET;
    hiAddr   = TOP_IDX - loAddr;
    swapEn   = writeOk && (loData > hiData);
    loWrData = hiData;
    hiWrData = loData;
  end

endmodule

// File: rtl/crush_datapath.sv
module crush_datapath
  import crush_pkg::*;
#(
  parameter int N     = 256,
  parameter int W     = 8,
  parameter int LANES = 2,
  parameter int AW    = $clog2(N),
  parameter int PORTS = 2 * LANES
) (
  input  logic                clk,
  input  logic                rstN,
  input  crushStrobes_t       strobes,
  output logic                atLast,
  output logic [PORTS*AW-1:0] rdAddr,
  input  logic [PORTS*W-1:0]  rdData,
  output logic [PORTS-1:0]    wrEn,
  output logic [PORTS*AW-1:0] wrAddr,
  output logic [PORTS*W-1:0]  wrData
);

  localparam logic [AW-1:0] LAST_IDX = AW'(N / 2 - LANES);
  localparam logic [AW-1:0] STEP     = AW'(LANES);

  logic [AW-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                idx <= '0;
    else if (strobes.clearIdx) idx <= '0;
    else if (strobes.advance)  idx <= idx + STEP;
  end

  assign atLast = (idx == LAST_IDX);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] loAddr, hiAddr;
    logic          swapEn;
    logic [W-1:0]  loWrData, hiWrData;

    crush_lane #(.N(N), .W(W), .AW(AW), .LANE_ID(l)) u_lane (
      .baseIdx (idx),
      .writeOk (strobes.writeOk),
      .loAddr  (loAddr),
      .hiAddr  (hiAddr),
      .loData  (rdData[(2*l)*W +: W]),
      .hiData  (rdData[(2*l+1)*W +: W]),
      .swapEn  (swapEn),
      .loWrData(loWrData),
      .hiWrData(hiWrData)
    );

    assign rdAddr[(2*l)*AW +: AW]   = loAddr;
    assign rdAddr[(2*l+1)*AW +: AW] = hiAddr;
    assign wrAddr[(2*l)*AW +: AW]   = loAddr;
    assign wrAddr[(2*l+1)*AW +: AW] = hiAddr;
    assign wrEn[2*l]                = swapEn;
    assign wrEn[2*l+1]              = swapEn;
    assign wrData[(2*l)*W +: W]     = loWrData;
    assign wrData[(2*l+1)*W +: W]   = hiWrData;
  end

  // R8: no writes leave the block outside a pass
  p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.writeOk |-> (wrEn == '0));

  // R5: a new pass begins at pair 0
  p_first_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearIdx |=> (rdAddr[AW-1:0] == '0));

  // R5: lane 0 moves forward by LANES pairs per busy cycle
  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !atLast) |=>
      (rdAddr[AW-1:0] == $past(rdAddr[AW-1:0]) + STEP));

endmodule

// File: rtl/mirror_crush.sv
module mirror_crush
  import crush_pkg::*;
#(
  parameter int N     = 256,
  parameter int W     = 8,
  parameter int LANES = 2,
  parameter int AW    = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  output logic                    done,
  output logic                    rdValid,
  output logic [2*LANES*AW-1:0]   rdAddr,
  input  logic [2*LANES*W-1:0]    rdData,
  output logic [2*LANES-1:0]      wrEn,
  output logic [2*LANES*AW-1:0]   wrAddr,
  output logic [2*LANES*W-1:0]    wrData
);

  localparam int PORTS = 2 * LANES;

  crushStrobes_t strobes;
  logic          atLast;
  logic          busy;

  crush_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .atLast (atLast),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  crush_datapath #(.N(N), .W(W), .LANES(LANES), .AW(AW), .PORTS(PORTS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .atLast (atLast),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

  assign rdValid = busy;

endmodule

// File: tb/mirror_crush_test.sv
module mirror_crush_test;

  localparam int N     = 16;
  localparam int W     = 8;
  localparam int LANES = 2;
  localparam int AW    = $clog2(N);
  localparam int PORTS = 2 * LANES;
  localparam int STEPS = N / PORTS;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic                  done, rdValid;
  logic [PORTS*AW-1:0]   rdAddr, wrAddr;
  logic [PORTS*W-1:0]    rdData, wrData;
  logic [PORTS-1:0]      wrEn;

  logic [W-1:0] mem   [N];
  logic [W-1:0] image [N];
  logic [W-1:0] expd  [N];
  logic [PORTS*AW-1:0] expQ [$];

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 0;

  always #4 clk = ~clk;

  mirror_crush #(.N(N), .W(W), .LANES(LANES), .AW(AW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .rdValid(rdValid),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // array model: combinational reads, writes at the clock edge
  always_comb begin
    for (int p = 0; p < PORTS; p++)
      rdData[p*W +: W] = mem[rdAddr[p*AW +: AW]];
  end

  always @(posedge clk) begin
    for (int p = 0; p < PORTS; p++)
      if (wrEn[p]) mem[wrAddr[p*AW +: AW]] <= wrData[p*W +: W];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard of read addresses and write activity
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected busy cycle", 1, 0);
      end else begin
        logic [PORTS*AW-1:0] e;
        logic [PORTS-1:0]    expWe;
        e = expQ.pop_front();
        check(rdAddr == e, "R5", "read addresses", int'(rdAddr), int'(e));
        for (int l = 0; l < LANES; l++) begin
          logic [W-1:0] lo, hi;
          lo = mem[e[(2*l)*AW +: AW]];
          hi = mem[e[(2*l+1)*AW +: AW]];
          expWe[2*l]   = lo > hi;
          expWe[2*l+1] = lo > hi;
          if (lo > hi && wrEn[2*l] && wrEn[2*l+1]) begin
            check(wrData[(2*l)*W +: W] == hi && wrAddr[(2*l)*AW +: AW] == e[(2*l)*AW +: AW],
                  "R5", "lower write port", int'(wrData[(2*l)*W +: W]), int'(hi));
            check(wrData[(2*l+1)*W +: W] == lo && wrAddr[(2*l+1)*AW +: AW] == e[(2*l+1)*AW +: AW],
                  "R5", "upper write port", int'(wrData[(2*l+1)*W +: W]), int'(lo));
          end
        end
        check(wrEn == expWe, "R2", "write enables", int'(wrEn), int'(expWe));
      end
    end else if (rstN && wrEn != '0) begin
      check(1'b0, "R8", "write while idle", int'(wrEn), 0);
    end
  end

  task automatic commitImage();
    for (int i = 0; i < N; i++) mem[i] <= image[i];
  endtask

  task automatic runPass(input int holdCycles, input bit checkDrop, input string tag);
    int cyc;
    int cnt [256];
    for (int i = 0; i < N; i++) expd[i] = image[i];
    for (int v = 0; v < N/2; v++)
      if (expd[v] > expd[N-1-v]) begin
        logic [W-1:0] t;
        t = expd[v]; expd[v] = expd[N-1-v]; expd[N-1-v] = t;
      end
    for (int s = 0; s < STEPS; s++) begin
      logic [PORTS*AW-1:0] e;
      for (int l = 0; l < LANES; l++) begin
        e[(2*l)*AW +: AW]   = AW'(s*LANES + l);
        e[(2*l+1)*AW +: AW] = AW'(N - 1 - (s*LANES + l));
      end
      expQ.push_back(e);
    end
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == holdCycles) start = 1'b0;
    end while (!done && cyc < 200);
    start = 1'b0;
    // R4: done on the STEPS-th edge after the start edge
    check(cyc - 1 == STEPS, "R4", {tag, " latency"}, cyc - 1, STEPS);
    for (int i = 0; i < N; i++)
      check(mem[i] == expd[i], "R2", {tag, " contents"}, int'(mem[i]), int'(expd[i]));
    for (int v = 0; v < N/2; v++)
      check(mem[v] <= mem[N-1-v], "R1", {tag, " pair order"}, int'(mem[v]), int'(mem[N-1-v]));
    for (int i = 0; i < 256; i++) cnt[i] = 0;
    for (int i = 0; i < N; i++) begin
      cnt[image[i]]++;
      cnt[mem[i]]--;
    end
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (cnt[i] != 0) bad++;
      check(bad == 0, "R7", {tag, " multiset"}, bad, 0);
    end
    for (int i = 0; i < N; i++) image[i] = expd[i];
    if (checkDrop) begin
      @(negedge clk);
      check(done == 1'b0, "R4", {tag, " done drop"}, int'(done), 0);
      repeat (2) @(negedge clk);
      check(expQ.size() == 0 && !rdValid, "R6", {tag, " no extra pass"}, expQ.size(), 0);
    end
  endtask

  task automatic randomPerm();
    for (int i = 0; i < N; i++) image[i] = W'(i * 13 + 7);
    for (int i = N - 1; i > 0; i--) begin
      int j;
      logic [W-1:0] t;
      j = int'($urandom_range(i, 0));
      t = image[i]; image[i] = image[j]; image[j] = t;
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(done == 1'b0 && rdValid == 1'b0 && wrEn == '0, "R8", "reset outputs",
          int'({done, rdValid, wrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && rdValid == 1'b0, "R8", "idle outputs", int'({done, rdValid}), 0);

    // already ordered: no writes
    for (int i = 0; i < N; i++) image[i] = W'(i);
    commitImage(); @(negedge clk);
    runPass(1, 1'b1, "identity R1");

    // fully reversed: every pair swaps
    for (int i = 0; i < N; i++) image[i] = W'(N - 1 - i);
    commitImage(); @(negedge clk);
    runPass(1, 1'b1, "reversed R2");

    // random permutations
    for (int k = 0; k < 6; k++) begin
      randomPerm(); commitImage(); @(negedge clk);
      runPass(1, 1'b1, "random R1");
    end

    // equal values: no writes
    for (int i = 0; i < N; i++) image[i] = 8'd5;
    commitImage(); @(negedge clk);
    runPass(1, 1'b1, "equal R2");

    // R3: unsigned compare, 0x80.. against 0x7F..
    for (int v = 0; v < N/2; v++) begin
      image[v]       = W'(8'h80 + v);
      image[N-1-v]   = W'(8'h7F - v);
    end
    commitImage(); @(negedge clk);
    runPass(1, 1'b1, "unsigned R3");
    check(mem[0] == 8'h7F, "R3", "low entry after swap", int'(mem[0]), 8'h7F);
    check(mem[N-1] == 8'h80, "R3", "high entry after swap", int'(mem[N-1]), 8'h80);

    // R6: start held through the busy cycles
    randomPerm(); commitImage(); @(negedge clk);
    runPass(3, 1'b1, "start held R6");

    // R9: start in the done cycle
    randomPerm(); commitImage(); @(negedge clk);
    runPass(1, 1'b0, "first of pair R9");
    runPass(1, 1'b1, "back to back R9");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule